// File: doc/BRIEF.md
# Flow-Hashed Header Dispatcher

This block sits in front of a stateful processing pipeline. Each cycle it can take one packet header together with the flow key that identifies the header's flow. It runs a CRC-16 over the key and uses the result to pick one of several FIFO queues. Because the choice depends only on the key, every header of a given flow goes to the same queue, and those headers keep their arrival order.

The same CRC also gives a short flow tag. The tag is stored with the header and the full key. A downstream scheduler can compare the narrow tag against the flows already in its pipeline and use the full key for the state access. Each queue shows its head entry and a not-empty flag. The scheduler pops a queue by raising that queue's grant bit.

A header that arrives for a full queue is lost, and a saturating counter records the loss. Different flows may hash into the same queue and may also share a tag.

Top module: `flow_dispatch`

## Requirements
- R1: While reset is asserted and right after it is released, every not-empty flag is 0 and the drop counter is 0.
- R2: The CRC is computed as follows. It uses polynomial 0x1021 and starts from 0xFFFF. It takes the key bits most significant first, one shift per bit. An accepted header is stored in the queue whose index equals the low log2(NQ) bits of this CRC.
- R3: Each head entry presents the stored header and full key unchanged. Its tag equals CRC bits [log2(NQ)+TAG_W-1 : log2(NQ)]. This holds when two different flows share a queue.
- R4: Within one queue, entries leave in the order they were accepted.
- R5: A queue never holds more than DEPTH entries. A header that arrives for a full queue without a pop of that queue in the same cycle is discarded, that queue's contents are unchanged, and the drop counter rises by exactly 1.
- R6: The drop counter saturates at all ones and does not wrap.
- R7: A push and a pop on the same queue in the same cycle both take effect. This also holds when the queue is full, in which case nothing is dropped.
- R8: A grant to an empty queue has no effect on any queue or on the counter.
- R9: While in_valid is low, the in_hdr and in_key values are ignored: no queue gains an entry and the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An arriving header is present |
| in_hdr | input | HDR_W | Header payload |
| in_key | input | KEY_W | Flow key of the header |
| pop | input | NQ | Per-queue grant; removes that queue's head |
| head_hdr | output | NQ*HDR_W | Head header of each queue, queue i at slice i |
| head_key | output | NQ*KEY_W | Head flow key of each queue |
| head_tag | output | NQ*TAG_W | Head flow tag of each queue |
| not_empty | output | NQ | Queue i holds at least one entry |
| drop_count | output | DROP_W | Saturating count of discarded headers |

## Verification
The assertions check four things on every cycle:
- no queue's occupancy exceeds its depth;
- the drop counter moves by at most one per cycle and stays pinned once saturated;
- idle input leaves the flags and the counter untouched;
- an empty queue stays empty when it is granted and nothing arrives.

Some behaviour only the bench's directed scenarios can show. These are the CRC-based queue choice and tag values, the order of entries within a queue, the fate of a header that hits a full queue, and the push-plus-pop case on a full queue. The bench checks them against its own queue model.

// File: rtl/flow_dispatch.sv
module flow_dispatch #(
  parameter int HDR_W  = 16,
  parameter int KEY_W  = 32,
  parameter int NQ     = 4,
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 4,
  parameter int DROP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [HDR_W-1:0]    in_hdr,
  input  logic [KEY_W-1:0]    in_key,
  input  logic [NQ-1:0]       pop,
  output logic [NQ*HDR_W-1:0] head_hdr,
  output logic [NQ*KEY_W-1:0] head_key,
  output logic [NQ*TAG_W-1:0] head_tag,
  output logic [NQ-1:0]       not_empty,
  output logic [DROP_W-1:0]   drop_count
);
  localparam int QB = $clog2(NQ);
  localparam int HB = QB + TAG_W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = TAG_W + KEY_W + HDR_W;

  function automatic logic [HB-1:0] key_hash(input logic [KEY_W-1:0] k);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = KEY_W - 1; i >= 0; i--)
      c = (c[15] ^ k[i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c[HB-1:0];
  endfunction

  wire [HB-1:0]    hval  = key_hash(in_key);
  wire [QB-1:0]    qsel  = hval[QB-1:0];
  wire [EW-1:0]    entry = {hval[HB-1:QB], in_key, in_hdr};
  logic [NQ-1:0]   lost;
  logic [NQ*CW-1:0] occ;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    wire hit  = in_valid && (qsel == QB'(g));
    wire full = (cnt == CW'(DEPTH));
    wire take = pop[g] && (cnt != '0);
    wire put  = hit && (!full || take);

    assign lost[g] = hit && full && !take;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (put)  wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (take) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(put) - CW'(take);
      end
    end

    always_ff @(posedge clk)
      if (put) mem[wp] <= entry;

    assign head_hdr[g*HDR_W +: HDR_W] = mem[rp][HDR_W-1:0];
    assign head_key[g*KEY_W +: KEY_W] = mem[rp][HDR_W +: KEY_W];
    assign head_tag[g*TAG_W +: TAG_W] = mem[rp][HDR_W+KEY_W +: TAG_W];
    assign not_empty[g]               = (cnt != '0);
    assign occ[g*CW +: CW]            = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              drop_count <= '0;
    else if ((|lost) && (drop_count != '1))  drop_count <= drop_count + 1'b1;
  end
endmodule

// File: rtl/flow_dispatch_chk.sv
module flow_dispatch_chk #(
  parameter int NQ     = 4,
  parameter int DEPTH  = 4,
  parameter int DROP_W = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [NQ-1:0]     pop,
  input logic [NQ-1:0]     not_empty,
  input logic [DROP_W-1:0] drop_count,
  input logic [NQ*CW-1:0]  occ
);
  for (genvar i = 0; i < NQ; i++) begin : g_a
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      occ[i*CW +: CW] <= CW'(DEPTH));
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!not_empty[i] && !in_valid) |=> !not_empty[i]);
  end

  p_drop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count - $past(drop_count)) <= DROP_W'(1));
  p_drop_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == '1) |=> (drop_count == '1));
  p_idle_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(drop_count));
  p_idle_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && pop == '0) |=> $stable(not_empty));
endmodule

bind flow_dispatch flow_dispatch_chk #(.NQ(NQ), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pop(pop),
  .not_empty(not_empty), .drop_count(drop_count), .occ(occ)
);

// File: tb/flow_dispatch_test.sv
`timescale 1ns/1ps
module flow_dispatch_test;
  localparam int HDR_W = 16, KEY_W = 32, NQ = 4, DEPTH = 4, TAG_W = 4, DROP_W = 4;
  localparam int QB = $clog2(NQ);
  localparam int DMAX = (1 << DROP_W) - 1;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [HDR_W-1:0] in_hdr = '0;
  logic [KEY_W-1:0] in_key = '0;
  logic [NQ-1:0] pop = '0;
  logic [NQ*HDR_W-1:0] head_hdr;
  logic [NQ*KEY_W-1:0] head_key;
  logic [NQ*TAG_W-1:0] head_tag;
  logic [NQ-1:0] not_empty;
  logic [DROP_W-1:0] drop_count;

  int total = 0, bad = 0;
  bit done = 0;
  logic [HDR_W-1:0] mh [NQ][DEPTH];
  logic [KEY_W-1:0] mk [NQ][DEPTH];
  int mc [NQ];
  int mdrop = 0;

  always #4 clk = ~clk;

  flow_dispatch #(.HDR_W(HDR_W), .KEY_W(KEY_W), .NQ(NQ), .DEPTH(DEPTH),
                  .TAG_W(TAG_W), .DROP_W(DROP_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_key(in_key),
    .pop(pop), .head_hdr(head_hdr), .head_key(head_key), .head_tag(head_tag),
    .not_empty(not_empty), .drop_count(drop_count));

  function automatic logic [15:0] crc(input logic [KEY_W-1:0] k);
    logic [15:0] c = 16'hFFFF;
    for (int i = KEY_W - 1; i >= 0; i--)
      c = (c[15] ^ k[i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c;
  endfunction

  function automatic logic [KEY_W-1:0] key_for(input int q, input logic [KEY_W-1:0] seed);
    logic [KEY_W-1:0] k = seed;
    logic [15:0] c = crc(k);
    while (int'(c[QB-1:0]) != q) begin
      k++;
      c = crc(k);
    end
    return k;
  endfunction

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic check_state(input string r);
    for (int i = 0; i < NQ; i++) begin
      chk(r, $sformatf("not_empty[%0d]", i), not_empty[i], mc[i] > 0);
      if (mc[i] > 0) begin
        logic [15:0] c = crc(mk[i][0]);
        chk(r, $sformatf("head_hdr[%0d]", i), head_hdr[i*HDR_W +: HDR_W], mh[i][0]);
        chk(r, $sformatf("head_key[%0d]", i), head_key[i*KEY_W +: KEY_W], mk[i][0]);
        chk(r, $sformatf("head_tag[%0d]", i), head_tag[i*TAG_W +: TAG_W], c[QB +: TAG_W]);
      end
    end
    chk(r, "drop_count", drop_count, mdrop);
  endtask

  task automatic step(input bit v, input logic [HDR_W-1:0] h, input logic [KEY_W-1:0] k,
                      input logic [NQ-1:0] pm);
    logic [15:0] c = crc(k);
    int q = int'(c[QB-1:0]);
    in_valid = v; in_hdr = h; in_key = k; pop = pm;
    @(posedge clk);
    for (int i = 0; i < NQ; i++)
      if (pm[i] && mc[i] > 0) begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          mh[i][j] = mh[i][j+1];
          mk[i][j] = mk[i][j+1];
        end
        mc[i]--;
      end
    if (v) begin
      if (mc[q] < DEPTH) begin
        mh[q][mc[q]] = h;
        mk[q][mc[q]] = k;
        mc[q]++;
      end else if (mdrop < DMAX) mdrop++;
    end
    @(negedge clk);
    in_valid = 0; pop = '0;
  endtask

  task automatic t_reset;
    check_state("R1");
  endtask

  task automatic t_spread;
    for (int q = 0; q < NQ; q++) step(1, HDR_W'(16'hA0 + q), key_for(q, KEY_W'(32'h1000 * (q + 1))), '0);
    check_state("R2");
    check_state("R3");
    step(0, '0, '0, '1);
    check_state("R2");
  endtask

  task automatic t_order;
    logic [KEY_W-1:0] k = key_for(2, 32'hCAFE0000);
    for (int n = 0; n < 3; n++) step(1, HDR_W'(16'h300 + n), k, '0);
    for (int n = 0; n < 3; n++) begin
      check_state("R4");
      chk("R4", "sequence", head_hdr[2*HDR_W +: HDR_W], 16'h300 + n);
      step(0, '0, '0, 4'b0100);
    end
    check_state("R4");
  endtask

  task automatic t_collide;
    logic [KEY_W-1:0] ka = key_for(1, 32'h5000_0000);
    logic [KEY_W-1:0] kb = key_for(1, ka + 1);
    step(1, 16'h11, ka, '0);
    step(1, 16'h22, kb, '0);
    step(1, 16'h33, ka, '0);
    for (int n = 0; n < 3; n++) begin
      check_state("R3");
      step(0, '0, '0, 4'b0010);
    end
    check_state("R4");
  endtask

  task automatic t_full;
    logic [KEY_W-1:0] k = key_for(0, 32'h7777_0000);
    for (int n = 0; n < DEPTH; n++) step(1, HDR_W'(16'h400 + n), k, '0);
    check_state("R5");
    step(1, 16'h4FF, k, '0);
    check_state("R5");
    chk("R5", "drop after full", drop_count, 1);
  endtask

  task automatic t_push_pop_full;
    logic [KEY_W-1:0] k = key_for(0, 32'h8888_0000);
    step(1, 16'h4AA, k, 4'b0001);
    check_state("R7");
    chk("R7", "no extra drop", drop_count, 1);
    chk("R7", "still full", mc[0], DEPTH);
    step(0, '0, '0, 4'b0011);
    check_state("R7");
  endtask

  task automatic t_empty_pop;
    for (int n = 0; n < DEPTH; n++) step(0, '0, '0, 4'b0001);
    check_state("R8");
    step(0, '0, '0, '1);
    check_state("R8");
    step(0, 16'hBEEF, key_for(3, 32'h9), '0);
    check_state("R9");
    chk("R9", "queue3 empty", not_empty[3], 0);
  endtask

  task automatic t_sat;
    logic [KEY_W-1:0] k = key_for(3, 32'hD000_0000);
    for (int n = 0; n < DEPTH + DMAX + 4; n++) step(1, HDR_W'(n), k, '0);
    check_state("R6");
    chk("R6", "saturated", drop_count, DMAX);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) mc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_spread;
    t_order;
    t_collide;
    t_full;
    t_push_pop_full;
    t_empty_pop;
    t_sat;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule